// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block recovers characters from an asynchronous serial line. A one-cycle enable, `tick8`, marks eight sampling points per bit period. The receiver hunts for a falling edge and confirms the start bit halfway through it. It then takes one sample per bit at the centre of each data bit, least significant bit first, followed by an optional parity bit and the stop bit. Each finished character goes out on a write port toward an external receive FIFO, with one error bit attached.

A framing fault and a parity fault raise the same error indication, so a consumer cannot tell them apart. If the FIFO reports full when a character completes, the character is dropped and an overrun pulse is raised. A loopback select feeds the receiver from the local transmitter output in place of the pin. With automatic flow control enabled, the ready-to-send output drops while the FIFO cannot take more data. Word length, stop-bit count and parity mode are captured when a start bit is confirmed and hold for the rest of that character.

Top module: `serial_rx`

## Requirements
- R1: While reset is held and after it is released, `fifo_wr`, `ovr_flag` and `err_flag` are 0 and `rts` is 1 until a character arrives.
- R2: A character is a low start bit, data bits least significant first, optional parity and stop, each bit lasting 8 ticks. Each completed character produces exactly one single-cycle `fifo_wr` pulse carrying its data in `fifo_wdata`.
- R3: The line must still read low on the 4th tick after the falling edge is seen, or the start is discarded and nothing is written.
- R4: `wlen` value 0, 1, 2 or 3 selects 5, 6, 7 or 8 data bits. Data bits above the selected length are written as 0.
- R5: `par_mode` value 0 gives no parity bit. Value 4 is odd, 5 is mark (bit must be 1), 6 is even and 7 is space (bit must be 0). A mismatched parity bit marks the character in error.
- R6: A stop bit sampled low marks the character in error. With `two_stop` = 1 only the first stop bit is checked, and a low level during the second stop period neither raises an error nor starts a new character.
- R7: Parity and framing faults share one indication: `fifo_werr` is 1 and `err_flag` pulses once for a character with either fault, and both stay 0 otherwise.
- R8: If `fifo_full` is 1 when a character completes, there is no write and `ovr_flag` pulses for one cycle instead.
- R9: With `loop_en` = 1 the receiver listens to `tx_loop` and ignores `rx_pin`. With `loop_en` = 0 it ignores `tx_loop`.
- R10: With `afc_en` = 1 and `fifo_full` = 1, `rts` goes to 0 on the next clock. In all other cases `rts` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tick8 | input | 1 | Sampling enable, eight per bit period |
| rx_pin | input | 1 | Serial input pin, idle high |
| tx_loop | input | 1 | Local transmitter output used in loopback |
| loop_en | input | 1 | 1 selects `tx_loop` as the line source |
| afc_en | input | 1 | Enables automatic ready-to-send control |
| wlen | input | 2 | Data length code, 0..3 for 5..8 bits |
| two_stop | input | 1 | 1 selects two stop bits |
| par_mode | input | 3 | Parity mode code |
| fifo_full | input | 1 | Receive FIFO cannot accept a write |
| fifo_wr | output | 1 | Write strobe toward the FIFO |
| fifo_wdata | output | 8 | Received character, upper bits zero |
| fifo_werr | output | 1 | Character had a parity or framing fault |
| ovr_flag | output | 1 | Pulse: character lost to a full FIFO |
| err_flag | output | 1 | Pulse: faulty character completed |
| rts | output | 1 | Ready-to-send, 1 means more data may come |

## Verification
A wrong bit index or a skewed tick counter shows up at the ports within one character. The data arrives shifted or truncated, or the stop bit is read from the wrong period and a spurious error appears. A receiver that fails to return to idle shows up as a missing write or as an extra character made from the tail of a stop period. The bench catches this by counting writes per frame as well as comparing their contents. The overrun and flow-control paths are one register deep, so any fault there is visible one clock after the character completes or after `fifo_full` changes.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    localparam int OSR       = 8;
    localparam int CNT_W     = $clog2(OSR);
    localparam int CHAR_W    = 8;
    localparam int CONFIRM_T = OSR / 2;

    typedef struct packed {
        logic [1:0] wlen;
        logic       two_stop;
        logic [2:0] par;
    } rx_cfg_t;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              err;
    } rx_char_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_STOP2
    } rx_state_e;

    function automatic logic [3:0] data_bits(input logic [1:0] wlen);
        return 4'd5 + {2'b00, wlen};
    endfunction

    function automatic logic [2:0] last_index(input logic [1:0] wlen);
        return 3'd4 + {1'b0, wlen};
    endfunction

    // mode[2] enables parity; mode[1:0]: 0 odd, 1 mark, 2 even, 3 space
    function automatic logic parity_bit(input logic [2:0] mode,
                                        input logic [1:0] wlen,
                                        input logic [CHAR_W-1:0] d);
        logic [CHAR_W-1:0] m;
        m = d & (8'hFF >> (2'd3 - wlen));
        case (mode[1:0])
            2'b00:   return ~^m;
            2'b01:   return 1'b1;
            2'b10:   return ^m;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/rx_line_sel.sv
module rx_line_sel #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic loop_en,
    input  logic rx_pin,
    input  logic tx_loop,
    output logic line_o
);
    logic raw;
    logic [SYNC_STAGES-1:0] chain;

    assign raw = loop_en ? tx_loop : rx_pin;

    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= 1'b1;
                else if (s == 0) chain[s] <= raw;
                else chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign line_o = chain[SYNC_STAGES-1];
endmodule

// File: rtl/rx_bit_engine.sv
module rx_bit_engine
    import serial_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     line,
    input  rx_cfg_t  cfg_i,
    output logic     done_o,
    output rx_char_t char_o
);
    rx_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [2:0]        idx;
    rx_cfg_t           cfg_q;
    logic [CHAR_W-1:0] data_q;
    logic              err_q;
    logic              at_sample;

    assign at_sample = (cnt == CNT_W'(OSR-1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            idx    <= '0;
            cfg_q  <= '0;
            data_q <= '0;
            err_q  <= 1'b0;
            done_o <= 1'b0;
            char_o <= '0;
        end else begin
            done_o <= 1'b0;
            if (tick) begin
                case (state)
                    ST_IDLE: begin
                        if (!line) begin
                            state <= ST_START;
                            cnt   <= CNT_W'(1);
                        end
                    end
                    ST_START: begin
                        if (cnt == CNT_W'(CONFIRM_T)) begin
                            cnt <= '0;
                            if (line) begin
                                state <= ST_IDLE;
                            end else begin
                                state  <= ST_DATA;
                                idx    <= '0;
                                data_q <= '0;
                                err_q  <= 1'b0;
                                cfg_q  <= cfg_i;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (at_sample) begin
                            cnt         <= '0;
                            data_q[idx] <= line;
                            if (idx == last_index(cfg_q.wlen))
                                state <= cfg_q.par[2] ? ST_PAR : ST_STOP;
                            else
                                idx <= idx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (at_sample) begin
                            cnt   <= '0;
                            state <= ST_STOP;
                            if (line != parity_bit(cfg_q.par, cfg_q.wlen, data_q))
                                err_q <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (at_sample) begin
                            cnt         <= '0;
                            done_o      <= 1'b1;
                            char_o.data <= data_q;
                            char_o.err  <= err_q | ~line;
                            state       <= cfg_q.two_stop ? ST_STOP2 : ST_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP2: begin
                        if (at_sample) begin
                            cnt   <= '0;
                            state <= ST_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    AST_DONE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(tick)); // R2

    AST_START_CONFIRMED_LOW: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_START && state == ST_DATA) |-> !$past(line)); // R3

    AST_UPPER_BITS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ((char_o.data >> data_bits(cfg_q.wlen)) == '0)); // R4
endmodule

// File: rtl/rx_flow_ctl.sv
module rx_flow_ctl
    import serial_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done_i,
    input  rx_char_t          char_i,
    input  logic              fifo_full,
    input  logic              afc_en,
    output logic              fifo_wr,
    output logic [CHAR_W-1:0] fifo_wdata,
    output logic              fifo_werr,
    output logic              ovr_flag,
    output logic              err_flag,
    output logic              rts
);
    always_ff @(posedge clk) begin
        if (rst) begin
            fifo_wr    <= 1'b0;
            fifo_wdata <= '0;
            fifo_werr  <= 1'b0;
            ovr_flag   <= 1'b0;
            err_flag   <= 1'b0;
            rts        <= 1'b1;
        end else begin
            fifo_wr  <= done_i & ~fifo_full;
            ovr_flag <= done_i & fifo_full;
            err_flag <= done_i & char_i.err;
            if (done_i) begin
                fifo_wdata <= char_i.data;
                fifo_werr  <= char_i.err;
            end
            rts <= ~(afc_en & fifo_full);
        end
    end

    AST_CHAR_ACCOUNTED: assert property (@(posedge clk) disable iff (rst)
        done_i |=> ($countones({fifo_wr, ovr_flag}) == 1)); // R8

    AST_WRITE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |=> !fifo_wr); // R2

    AST_RTS_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (afc_en && fifo_full) |=> !rts); // R10
endmodule

// File: rtl/serial_rx.sv
module serial_rx
    import serial_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick8,
    input  logic       rx_pin,
    input  logic       tx_loop,
    input  logic       loop_en,
    input  logic       afc_en,
    input  logic [1:0] wlen,
    input  logic       two_stop,
    input  logic [2:0] par_mode,
    input  logic       fifo_full,
    output logic       fifo_wr,
    output logic [7:0] fifo_wdata,
    output logic       fifo_werr,
    output logic       ovr_flag,
    output logic       err_flag,
    output logic       rts
);
    logic     line;
    logic     done;
    rx_char_t chr;
    rx_cfg_t  cfg;

    assign cfg = '{wlen: wlen, two_stop: two_stop, par: par_mode};

    rx_line_sel #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk     (clk),
        .rst     (rst),
        .loop_en (loop_en),
        .rx_pin  (rx_pin),
        .tx_loop (tx_loop),
        .line_o  (line)
    );

    rx_bit_engine u_engine (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick8),
        .line   (line),
        .cfg_i  (cfg),
        .done_o (done),
        .char_o (chr)
    );

    rx_flow_ctl u_flow (
        .clk        (clk),
        .rst        (rst),
        .done_i     (done),
        .char_i     (chr),
        .fifo_full  (fifo_full),
        .afc_en     (afc_en),
        .fifo_wr    (fifo_wr),
        .fifo_wdata (fifo_wdata),
        .fifo_werr  (fifo_werr),
        .ovr_flag   (ovr_flag),
        .err_flag   (err_flag),
        .rts        (rts)
    );
endmodule

// File: tb/serial_rx_tb.sv
`timescale 1ns/1ps
module serial_rx_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick8;
    logic drv = 1'b1, pin_hold = 1'b1, route_loop = 1'b0;
    logic loop_en = 1'b0, afc_en = 1'b0, two_stop = 1'b0, fifo_full = 1'b0;
    logic [1:0] wlen = 2'd3;
    logic [2:0] par_mode = 3'd0;
    logic rx_pin, tx_loop;
    logic fifo_wr, fifo_werr, ovr_flag, err_flag, rts;
    logic [7:0] fifo_wdata;
    logic [1:0] tcnt = 2'd0;

    int checks = 0, errors = 0;
    int wr_cnt = 0, ovr_cnt = 0, err_cnt = 0;
    logic [7:0] last_data = 8'h00;
    logic last_err = 1'b0;

    always #2 clk = ~clk;

    always @(posedge clk) tcnt <= tcnt + 2'd1;
    assign tick8 = (tcnt == 2'd3);

    assign rx_pin  = route_loop ? pin_hold : drv;
    assign tx_loop = route_loop ? drv : 1'b1;

    serial_rx u_dut (
        .clk(clk), .rst(rst), .tick8(tick8), .rx_pin(rx_pin), .tx_loop(tx_loop),
        .loop_en(loop_en), .afc_en(afc_en), .wlen(wlen), .two_stop(two_stop),
        .par_mode(par_mode), .fifo_full(fifo_full), .fifo_wr(fifo_wr),
        .fifo_wdata(fifo_wdata), .fifo_werr(fifo_werr), .ovr_flag(ovr_flag),
        .err_flag(err_flag), .rts(rts)
    );

    always @(negedge clk) begin
        if (fifo_wr) begin
            wr_cnt++;
            last_data = fifo_wdata;
            last_err  = fifo_werr;
        end
        if (ovr_flag) ovr_cnt++;
        if (err_flag) err_cnt++;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bit_period(input logic v);
        drv = v;
        repeat (32) @(negedge clk);
    endtask

    function automatic logic tb_parity(input logic [2:0] m, input logic [7:0] d, input int n);
        int ones = 0;
        for (int i = 0; i < n; i++) ones += d[i];
        case (m)
            3'd4:    return (ones % 2 == 0);
            3'd5:    return 1'b1;
            3'd6:    return (ones % 2 == 1);
            default: return 1'b0;
        endcase
    endfunction

    task automatic send(input logic [7:0] d, input int n, input logic [2:0] m,
                        input logic bad_par, input logic stop1,
                        input logic extra, input logic stop2);
        bit_period(1'b0);
        for (int i = 0; i < n; i++) bit_period(d[i]);
        if (m[2]) bit_period(tb_parity(m, d, n) ^ bad_par);
        bit_period(stop1);
        if (extra) bit_period(stop2);
        drv = 1'b1;
    endtask

    task automatic idle(input int bits);
        drv = 1'b1;
        repeat (32 * bits) @(negedge clk);
    endtask

    // wlen, par, data, bad_par, stop_low, exp_data, exp_err
    localparam int NV = 10;
    localparam logic [23:0] VEC [NV] = '{
        {2'd3, 3'd0, 8'hA5, 1'b0, 1'b0, 8'hA5, 1'b0},
        {2'd3, 3'd6, 8'hA5, 1'b0, 1'b0, 8'hA5, 1'b0},
        {2'd3, 3'd4, 8'h3C, 1'b0, 1'b0, 8'h3C, 1'b0},
        {2'd3, 3'd6, 8'h81, 1'b1, 1'b0, 8'h81, 1'b1},
        {2'd0, 3'd0, 8'hFF, 1'b0, 1'b0, 8'h1F, 1'b0},
        {2'd1, 3'd5, 8'hEA, 1'b0, 1'b0, 8'h2A, 1'b0},
        {2'd2, 3'd7, 8'hD5, 1'b0, 1'b0, 8'h55, 1'b0},
        {2'd2, 3'd7, 8'h12, 1'b1, 1'b0, 8'h12, 1'b1},
        {2'd3, 3'd0, 8'h5A, 1'b0, 1'b1, 8'h5A, 1'b1},
        {2'd3, 3'd5, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1}
    };

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int w0, o0, e0;
        repeat (4) @(negedge clk);
        chk("R1 wr in reset", fifo_wr, 0);
        chk("R1 rts in reset", rts, 1);
        rst = 1'b0;
        repeat (40) @(negedge clk);
        chk("R1 ovr idle", ovr_flag, 0);
        chk("R1 err idle", err_flag, 0);
        chk("R1 rts idle", rts, 1);
        chk("R1 no writes", wr_cnt, 0);

        // R2 R4 R5 R6 R7: table walk
        for (int v = 0; v < NV; v++) begin
            wlen = VEC[v][23:22];
            par_mode = VEC[v][21:19];
            w0 = wr_cnt; e0 = err_cnt;
            send(VEC[v][18:11], int'(VEC[v][23:22]) + 5, VEC[v][21:19],
                 VEC[v][10], ~VEC[v][9], 1'b0, 1'b1);
            idle(3);
            chk($sformatf("R2 vec%0d write count", v), wr_cnt - w0, 1);
            chk($sformatf("R4 vec%0d data", v), last_data, VEC[v][8:1]);
            chk($sformatf("R7 vec%0d err bit", v), last_err, VEC[v][0]);
            chk($sformatf("R7 vec%0d err pulses", v), err_cnt - e0, VEC[v][0]);
        end
        wlen = 2'd3; par_mode = 3'd0;

        // R3: short low glitch rejected
        w0 = wr_cnt;
        drv = 1'b0; repeat (8) @(negedge clk); drv = 1'b1;
        idle(12);
        chk("R3 glitch no write", wr_cnt - w0, 0);

        // R6: second stop low ignored in two-stop mode
        two_stop = 1'b1; w0 = wr_cnt; e0 = err_cnt;
        send(8'h96, 8, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0);
        idle(12);
        chk("R6 two-stop writes", wr_cnt - w0, 1);
        chk("R6 two-stop data", last_data, 8'h96);
        chk("R6 two-stop no err", err_cnt - e0, 0);
        // same line in one-stop mode: low becomes a new start
        two_stop = 1'b0; w0 = wr_cnt;
        send(8'h96, 8, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0);
        idle(12);
        chk("R6 one-stop writes", wr_cnt - w0, 2);
        chk("R6 one-stop extra char", last_data, 8'hFF);

        // R9: loopback
        route_loop = 1'b1; loop_en = 1'b1; pin_hold = 1'b0; w0 = wr_cnt;
        send(8'h69, 8, 3'd0, 1'b0, 1'b1, 1'b0, 1'b1);
        idle(3);
        chk("R9 loop write", wr_cnt - w0, 1);
        chk("R9 loop data", last_data, 8'h69);
        pin_hold = 1'b1; loop_en = 1'b0; w0 = wr_cnt;
        send(8'h00, 8, 3'd0, 1'b0, 1'b1, 1'b0, 1'b1);
        idle(3);
        chk("R9 tx_loop ignored", wr_cnt - w0, 0);
        route_loop = 1'b0;
        idle(2);

        // R8 R10: full FIFO
        fifo_full = 1'b1; afc_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 rts without afc", rts, 1);
        w0 = wr_cnt; o0 = ovr_cnt;
        send(8'h33, 8, 3'd0, 1'b0, 1'b1, 1'b0, 1'b1);
        idle(3);
        chk("R8 no write when full", wr_cnt - w0, 0);
        chk("R8 overrun pulse", ovr_cnt - o0, 1);
        afc_en = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 rts dropped", rts, 0);
        fifo_full = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 rts restored", rts, 1);
        w0 = wr_cnt; o0 = ovr_cnt;
        send(8'hC3, 8, 3'd0, 1'b0, 1'b1, 1'b0, 1'b1);
        idle(3);
        chk("R8 write after space", wr_cnt - w0, 1);
        chk("R8 no overrun", ovr_cnt - o0, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule